// File: doc/BRIEF.md
# Transmit Checksum Inserter

This block sits on a byte-wide transmit stream and fills in checksums before frames leave the chip. Each frame is held whole in an internal buffer. While the frame is written, the block reads the Ethernet type, the IPv4 header fields and the layer-4 protocol, and it accumulates the ones-complement sums it needs. After the final byte arrives, one cycle folds the sums. The block then sends the frame with the IPv4 header checksum and the TCP, UDP or ICMP checksum written into their fields.

Software picks the checksum kinds through an enable register. That register may only change while the transmit side is paused. Software clears the run input, waits for the busy output to drop, then writes. A frame the buffer cannot hold leaves unmodified. Its buffered head is sent first and the rest is passed straight from input to output.

Top module: `tx_csum_inserter`

## Requirements
- R1: A frame qualifies as IPv4 when bytes 12..13 hold 0x0800, the high nibble of byte 14 is 4, and its low nibble (IHL) is at least 5. The total length in bytes 16..17 must be at least IHL*4, and the frame must hold at least 14 + total length bytes. For such a frame with enable bit 0 set, bytes 24..25 carry the ones-complement of the folded 16-bit sum of the IHL*4 header bytes starting at byte 14, with the checksum field counted as zero.
- R2: For a qualifying frame with protocol byte 23 equal to 6 and enable bit 4 set, the checksum is written at layer-4 offset 16. The layer-4 part starts at byte 14 + IHL*4 and ends at byte 14 + total length. Its sum covers those bytes, with an odd last byte padded by a zero low byte and trailing pad bytes excluded. The sum adds a pseudo-header: the source and destination addresses, the protocol and the layer-4 length.
- R3: For protocol 17 with enable bit 5 set, the checksum is computed the same way and written at layer-4 offset 6. A computed value of 0x0000 is sent as 0xFFFF.
- R4: A UDP datagram whose checksum field arrives as 0x0000 leaves with that field still 0x0000.
- R5: For protocol 1 with enable bit 6 set, the checksum over the layer-4 bytes is written at layer-4 offset 2, with no pseudo-header.
- R6: Non-IPv4 frames, including tagged frames (type 0x8100), other protocols and kinds whose enable bit is clear all leave with their checksum fields untouched. Every byte that is not an enabled checksum field is passed unchanged.
- R7: No output byte is offered before the input byte marked last has been accepted. The output frame has the input frame's length, with outLast on its final byte.
- R8: A frame longer than DEPTH bytes leaves complete, with its length and all bytes unchanged.
- R9: The enable register resets to 0. A write is taken only while runEn is 0 and busy is 0, and it stores the written value ANDed with 0x0F700071. Bits 20..22 and 24..27 are kept but have no effect on frames.
- R10: While runEn is 0, no new frame is started (inReady stays 0). A frame already in flight completes, and busy falls after its final output byte.
- R11: While outValid is 1 and outReady is 0, outValid and outData hold, except in the pass-through tail of an oversized frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Run request; 0 pauses at a frame boundary |
| cfgWr | input | 1 | Enable register write strobe |
| cfgData | input | 32 | Enable register write value |
| enable | output | 32 | Current enable register value |
| busy | output | 1 | 1 while a frame is being received, processed or sent |
| inData | input | 8 | Input byte |
| inValid | input | 1 | Input byte valid |
| inLast | input | 1 | Input byte is the last of its frame |
| inReady | output | 1 | Input byte accepted when high with inValid |
| outData | output | 8 | Output byte |
| outValid | output | 1 | Output byte valid |
| outLast | output | 1 | Output byte is the last of its frame |
| outReady | input | 1 | Sink accepts the output byte |

## Verification
The run bit and the enable write can meet while a frame is in flight. The bench clears runEn and attempts a cfgWr of zero after the third input byte of a TCP frame. It then expects three things: the frame still leaves with both checksums inserted under the old enables, the enable output keeps its value, and busy drops with no further input accepted. A second overlap is backpressure landing on substituted bytes. A one-in-three stall pattern on outReady makes stalls fall on the header and layer-4 checksum bytes, and the bench requires each stalled byte to hold and the finished frame to match the computed image.

// File: rtl/txcs_pkg.sv
`timescale 1ns/1ps
package txcs_pkg;

  typedef struct packed {
    logic clrFrame;
    logic wrEn;
    logic calc;
    logic rdAdv;
    logic modOut;
    logic thruSel;
  } dpCtl_t;

  localparam logic [31:0] EN_MASK = 32'h0F70_0071;
  localparam int EN_IP   = 0;
  localparam int EN_TCP  = 4;
  localparam int EN_UDP  = 5;
  localparam int EN_ICMP = 6;

  localparam logic [15:0] ETH_IPV4    = 16'h0800;
  localparam logic [15:0] OFF_TYPE_HI = 16'd12;
  localparam logic [15:0] OFF_TYPE_LO = 16'd13;
  localparam logic [15:0] OFF_IP      = 16'd14;
  localparam logic [15:0] OFF_LEN_HI  = 16'd16;
  localparam logic [15:0] OFF_LEN_LO  = 16'd17;
  localparam logic [15:0] OFF_PROTO   = 16'd23;
  localparam logic [15:0] OFF_IPCS    = 16'd24;
  localparam logic [15:0] OFF_ADDR_LO = 16'd26;
  localparam logic [15:0] OFF_ADDR_HI = 16'd33;
  localparam logic [15:0] OFF_L4_MIN  = 16'd34;

  localparam logic [7:0] PROTO_ICMP = 8'd1;
  localparam logic [7:0] PROTO_TCP  = 8'd6;
  localparam logic [7:0] PROTO_UDP  = 8'd17;

  function automatic logic [15:0] foldSum(input logic [31:0] s);
    logic [16:0] a;
    logic [16:0] b;
    a = {1'b0, s[15:0]} + {1'b0, s[31:16]};
    b = {1'b0, a[15:0]} + {16'h0, a[16]};
    return b[15:0];
  endfunction

  function automatic logic [15:0] csRel(input logic [7:0] p);
    case (p)
      PROTO_TCP:  return 16'd16;
      PROTO_UDP:  return 16'd6;
      PROTO_ICMP: return 16'd2;
      default:    return 16'd0;
    endcase
  endfunction

endpackage

// File: rtl/txcs_ctrl.sv
`timescale 1ns/1ps
module txcs_ctrl
  import txcs_pkg::*;
#(
  parameter int DEPTH = 2048
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        runEn,
  input  logic        cfgWr,
  input  logic [31:0] cfgData,
  output logic [31:0] enable,
  output logic        busy,
  input  logic        inValid,
  input  logic        inLast,
  output logic        inReady,
  output logic        outValid,
  output logic        outLast,
  input  logic        outReady,
  input  logic        bufFull,
  input  logic        rdLast,
  input  logic        rdTop,
  output dpCtl_t      ctl
);

  typedef enum logic [2:0] {S_IDLE, S_RECV, S_CALC, S_SEND, S_SPILL, S_THRU} state_t;
  state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    inReady   = 1'b0;
    outValid  = 1'b0;
    outLast   = 1'b0;
    case (state)
      S_IDLE: begin
        ctl.clrFrame = 1'b1;
        if (runEn && inValid) nextState = S_RECV;
      end
      S_RECV: begin
        inReady   = 1'b1;
        ctl.wrEn  = inValid;
        if (inValid) begin
          if (inLast)       nextState = S_CALC;
          else if (bufFull) nextState = S_SPILL;
        end
      end
      S_CALC: begin
        ctl.calc  = 1'b1;
        nextState = S_SEND;
      end
      S_SEND: begin
        outValid   = 1'b1;
        outLast    = rdLast;
        ctl.modOut = 1'b1;
        if (outReady) begin
          ctl.rdAdv = 1'b1;
          if (rdLast) nextState = S_IDLE;
        end
      end
      S_SPILL: begin
        outValid = 1'b1;
        if (outReady) begin
          ctl.rdAdv = 1'b1;
          if (rdTop) nextState = S_THRU;
        end
      end
      S_THRU: begin
        ctl.thruSel = 1'b1;
        outValid    = inValid;
        outLast     = inLast;
        inReady     = outReady;
        if (inValid && outReady && inLast) nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) enable <= '0;
    else if (cfgWr && !runEn && state == S_IDLE) enable <= cfgData & EN_MASK;
  end

  // R9
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && (runEn || busy)) |=> $stable(enable));

  // R10
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(outValid && outReady && outLast));

endmodule

// File: rtl/txcs_datapath.sv
`timescale 1ns/1ps
module txcs_datapath
  import txcs_pkg::*;
#(
  parameter int DEPTH = 2048
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpCtl_t      ctl,
  input  logic [31:0] enable,
  input  logic [7:0]  inData,
  output logic [7:0]  outData,
  output logic        bufFull,
  output logic        rdLast,
  output logic        rdTop
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] rdPtr;

  logic [15:0] ethType, hdrEnd, l4End, csOff, origCs;
  logic [7:0]  verIhl, lenHi, proto;
  logic [31:0] ipSum, l4Sum, phSum;
  logic        modIp, modL4;
  logic [15:0] ipCsQ, l4CsQ;

  logic [31:0] unusedEn;
  assign unusedEn = enable;

  // write-side decode
  logic [15:0] idx16;
  logic [31:0] word32;
  logic        inIp, inL4, inAddr;
  assign idx16  = 16'(cnt);
  assign word32 = idx16[0] ? {24'h0, inData} : {16'h0, inData, 8'h0};
  assign inIp   = (idx16 == OFF_IP) ||
                  ((idx16 > OFF_IP) && (idx16 < hdrEnd) &&
                   (idx16 != OFF_IPCS) && (idx16 != OFF_IPCS + 16'd1));
  assign inL4   = (idx16 >= OFF_L4_MIN) && (idx16 >= hdrEnd) && (idx16 < l4End) &&
                  (idx16 != csOff) && (idx16 != csOff + 16'd1);
  assign inAddr = (idx16 >= OFF_ADDR_LO) && (idx16 <= OFF_ADDR_HI);

  always_ff @(posedge clk) begin
    if (ctl.wrEn) mem[cnt[IDX_W-1:0]] <= inData;
  end

  // completion-side decision
  logic [15:0] l4Len, rel, frameLen16, ipCsC, l4CsC;
  logic [31:0] l4Total;
  logic        isIp4, fits, selTcp, selUdp, selIcmp;
  always_comb begin
    l4Len      = l4End - hdrEnd;
    frameLen16 = 16'(cnt);
    rel        = csRel(proto);
    isIp4      = (ethType == ETH_IPV4) && (verIhl[7:4] == 4'd4) && (verIhl[3:0] >= 4'd5) &&
                 (frameLen16 >= l4End) && (l4End >= hdrEnd);
    fits       = (rel != 16'd0) && (l4Len >= rel + 16'd2);
    selTcp     = (proto == PROTO_TCP)  && enable[EN_TCP];
    selUdp     = (proto == PROTO_UDP)  && enable[EN_UDP] && (origCs != 16'h0);
    selIcmp    = (proto == PROTO_ICMP) && enable[EN_ICMP];
    l4Total    = l4Sum;
    if (proto != PROTO_ICMP) l4Total = l4Sum + phSum + {24'h0, proto} + {16'h0, l4Len};
    ipCsC      = ~foldSum(ipSum);
    l4CsC      = ~foldSum(l4Total);
    if ((proto == PROTO_UDP) && (l4CsC == 16'h0)) l4CsC = 16'hFFFF;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clrFrame) begin
      cnt <= '0; rdPtr <= '0;
      ethType <= '0; hdrEnd <= '0; l4End <= '0; csOff <= '0; origCs <= '0;
      verIhl <= '0; lenHi <= '0; proto <= '0;
      ipSum <= '0; l4Sum <= '0; phSum <= '0;
      modIp <= 1'b0; modL4 <= 1'b0; ipCsQ <= '0; l4CsQ <= '0;
    end else begin
      if (ctl.wrEn) begin
        cnt <= cnt + CNT_W'(1);
        if (idx16 == OFF_TYPE_HI) ethType[15:8] <= inData;
        if (idx16 == OFF_TYPE_LO) ethType[7:0]  <= inData;
        if (idx16 == OFF_IP) begin
          verIhl <= inData;
          hdrEnd <= OFF_IP + {10'h0, inData[3:0], 2'b00};
        end
        if (idx16 == OFF_LEN_HI) lenHi <= inData;
        if (idx16 == OFF_LEN_LO) l4End <= OFF_IP + {lenHi, inData};
        if (idx16 == OFF_PROTO) begin
          proto <= inData;
          csOff <= hdrEnd + csRel(inData);
        end
        if (idx16 == csOff)         origCs[15:8] <= inData;
        if (idx16 == csOff + 16'd1) origCs[7:0]  <= inData;
        if (inIp)   ipSum <= ipSum + word32;
        if (inAddr) phSum <= phSum + word32;
        if (inL4)   l4Sum <= l4Sum + word32;
      end
      if (ctl.calc) begin
        modIp <= isIp4 && enable[EN_IP];
        modL4 <= isIp4 && fits && (selTcp || selUdp || selIcmp);
        ipCsQ <= ipCsC;
        l4CsQ <= l4CsC;
      end
      if (ctl.rdAdv) rdPtr <= rdPtr + IDX_W'(1);
    end
  end

  assign bufFull = (cnt == CNT_W'(DEPTH - 1));
  assign rdTop   = (rdPtr == IDX_W'(DEPTH - 1));
  assign rdLast  = ((CNT_W'(rdPtr) + CNT_W'(1)) == cnt);

  logic [15:0] rd16;
  assign rd16 = 16'(rdPtr);
  always_comb begin
    outData = mem[rdPtr];
    if (ctl.modOut) begin
      if (modIp && rd16 == OFF_IPCS)          outData = ipCsQ[15:8];
      if (modIp && rd16 == OFF_IPCS + 16'd1)  outData = ipCsQ[7:0];
      if (modL4 && rd16 == csOff)             outData = l4CsQ[15:8];
      if (modL4 && rd16 == csOff + 16'd1)     outData = l4CsQ[7:0];
    end
    if (ctl.thruSel) outData = inData;
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrEn |-> (cnt < CNT_W'(DEPTH)));

  // R7
  nonempty_calc_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.calc |-> (cnt != '0));

endmodule

// File: rtl/tx_csum_inserter.sv
`timescale 1ns/1ps
module tx_csum_inserter
  import txcs_pkg::*;
#(
  parameter int DEPTH = 2048
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        runEn,
  input  logic        cfgWr,
  input  logic [31:0] cfgData,
  output logic [31:0] enable,
  output logic        busy,
  input  logic [7:0]  inData,
  input  logic        inValid,
  input  logic        inLast,
  output logic        inReady,
  output logic [7:0]  outData,
  output logic        outValid,
  output logic        outLast,
  input  logic        outReady
);

  dpCtl_t ctl;
  logic   bufFull, rdLast, rdTop;

  txcs_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .cfgWr(cfgWr), .cfgData(cfgData),
    .enable(enable), .busy(busy), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .outValid(outValid), .outLast(outLast), .outReady(outReady),
    .bufFull(bufFull), .rdLast(rdLast), .rdTop(rdTop), .ctl(ctl)
  );

  txcs_datapath #(.DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .enable(enable), .inData(inData),
    .outData(outData), .bufFull(bufFull), .rdLast(rdLast), .rdTop(rdTop)
  );

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !ctl.thruSel) |=> (outValid && $stable(outData)));

endmodule

// File: tb/tb_tx_csum_inserter.sv
`timescale 1ns/1ps
module tb_tx_csum_inserter;

  localparam int DEPTH = 128;
  localparam logic [31:0] ALL_EN = 32'h0F70_0071;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic        cfgWr = 1'b0;
  logic [31:0] cfgData = '0;
  logic [31:0] enable;
  logic        busy;
  logic [7:0]  inData = '0;
  logic        inValid = 1'b0;
  logic        inLast = 1'b0;
  logic        inReady;
  logic [7:0]  outData;
  logic        outValid;
  logic        outLast;
  logic        outReady = 1'b0;

  tx_csum_inserter #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .cfgWr(cfgWr), .cfgData(cfgData),
    .enable(enable), .busy(busy), .inData(inData), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .outData(outData), .outValid(outValid), .outLast(outLast),
    .outReady(outReady)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  logic [31:0] curEn = '0;
  logic [7:0] fin  [0:255];
  logic [7:0] fexp [0:255];
  logic [7:0] fout [0:255];
  int flen = 0;
  int outCnt = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] fold16(input int s);
    int t = s;
    while ((t >> 16) != 0) t = (t & 16'hFFFF) + (t >> 16);
    return 16'(t);
  endfunction

  // expected output image computed from the requirements
  function automatic void refModel(input logic [31:0] en);
    int et, ihl, hl, tot, off, l4, rel, s, pr;
    logic [15:0] c;
    for (int i = 0; i < flen; i++) fexp[i] = fin[i];
    if (flen > DEPTH) return;
    et  = {fin[12], fin[13]};
    ihl = int'(fin[14][3:0]);
    hl  = ihl * 4;
    tot = {fin[16], fin[17]};
    if (!(et == 16'h0800 && fin[14][7:4] == 4'd4 && ihl >= 5 && flen >= 14 + tot && tot >= hl)) return;
    if (en[0]) begin
      s = 0;
      for (int i = 14; i < 14 + hl; i += 2) if (i != 24) s += {fin[i], fin[i+1]};
      c = ~fold16(s);
      fexp[24] = c[15:8]; fexp[25] = c[7:0];
    end
    pr  = int'(fin[23]);
    off = 14 + hl;
    l4  = tot - hl;
    rel = (pr == 6 && en[4]) ? 16 : (pr == 17 && en[5]) ? 6 : (pr == 1 && en[6]) ? 2 : 0;
    if (rel == 0 || l4 < rel + 2) return;
    if (pr == 17 && fin[off+6] == 0 && fin[off+7] == 0) return;
    s = 0;
    for (int i = off; i < 14 + tot; i += 2)
      if (i != off + rel) s += {fin[i], (i + 1 < 14 + tot) ? fin[i+1] : 8'h00};
    if (pr != 1)
      s += {fin[26], fin[27]} + {fin[28], fin[29]} + {fin[30], fin[31]} + {fin[32], fin[33]} + pr + l4;
    c = ~fold16(s);
    if (pr == 17 && c == 16'h0) c = 16'hFFFF;
    fexp[off+rel] = c[15:8]; fexp[off+rel+1] = c[7:0];
  endfunction

  task automatic mkFrame(input int et, input int ihl, input int pr, input int l4len,
                         input int padTo, input bit udpZero);
    int off = 14 + ihl * 4;
    int tot = ihl * 4 + l4len;
    flen = off + l4len;
    for (int i = 0; i < 12; i++) fin[i] = 8'(i * 3 + 1);
    fin[12] = 8'(et >> 8); fin[13] = 8'(et);
    fin[14] = 8'(8'h40 | ihl); fin[15] = 8'h00;
    fin[16] = 8'(tot >> 8); fin[17] = 8'(tot);
    fin[18] = 8'h12; fin[19] = 8'h34; fin[20] = 8'h40; fin[21] = 8'h00;
    fin[22] = 8'd64; fin[23] = 8'(pr); fin[24] = 8'hAB; fin[25] = 8'hCD;
    fin[26] = 8'd10; fin[27] = 8'd0; fin[28] = 8'd0; fin[29] = 8'd1;
    fin[30] = 8'd192; fin[31] = 8'd168; fin[32] = 8'd1; fin[33] = 8'd77;
    for (int i = 34; i < off; i++) fin[i] = 8'h01;
    for (int k = 0; k < l4len; k++) fin[off+k] = 8'(k * 7 + 3);
    if (pr == 17) begin
      fin[off+4] = 8'(l4len >> 8); fin[off+5] = 8'(l4len);
      if (udpZero) begin fin[off+6] = 8'h00; fin[off+7] = 8'h00; end
    end
    while (flen < padTo) begin fin[flen] = 8'h5A; flen++; end
  endtask

  task automatic runFrame(input string tag, input bit stall, input bit big, input bit dropRun);
    int inIdx = 0, cyc = 0;
    bit lastIn = 0, done = 0, early = 0, holdBad = 0, prevStall = 0, dropped = 0;
    bit inFire, outFire;
    logic [7:0] prevData = '0;
    int bad = 0;
    refModel(curEn);
    outCnt = 0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cfgWr = 1'b0;
      outReady = stall ? ((cyc % 3) != 2) : 1'b1;
      if (inIdx < flen) begin
        inValid = 1'b1; inData = fin[inIdx]; inLast = (inIdx == flen - 1);
      end else begin
        inValid = 1'b0; inLast = 1'b0;
      end
      if (dropRun && inIdx == 3 && !dropped) begin
        runEn = 1'b0; cfgWr = 1'b1; cfgData = 32'h0; dropped = 1;
      end
      #2;
      if (prevStall && !big && (!outValid || outData != prevData)) holdBad = 1;
      if (outValid && !lastIn && !big) early = 1;
      inFire  = inValid && inReady;
      outFire = outValid && outReady;
      if (outFire) begin
        fout[outCnt] = outData;
        outCnt++;
        if (outLast) done = 1;
      end
      prevStall = outValid && !outReady;
      prevData  = outData;
      if (inFire) begin
        inIdx++;
        if (inLast) lastIn = 1;
      end
      cyc++;
    end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0; cfgWr = 1'b0;
    chk(done, tag, "frame completed", done, 1);
    chk(outCnt == flen, tag, "output length", outCnt, flen);
    for (int i = 0; i < flen && i < outCnt; i++) if (fout[i] !== fexp[i]) bad++;
    chk(bad == 0, tag, "mismatching bytes", bad, 0);
    if (!big) chk(!early, "R7", "output before last input accepted", early, 0);
    if (stall) chk(!holdBad, "R11", "data held under stall", holdBad, 0);
  endtask

  task automatic setEn(input logic [31:0] v);
    @(negedge clk);
    runEn = 1'b0;
    while (busy) @(negedge clk);
    cfgWr = 1'b1; cfgData = v;
    @(negedge clk);
    cfgWr = 1'b0; runEn = 1'b1;
    curEn = v & ALL_EN;
  endtask

  task automatic testReset();
    #2;
    chk(busy == 1'b0, "R10", "busy in reset", busy, 0);
    chk(outValid == 1'b0, "R7", "outValid in reset", outValid, 0);
    chk(enable == 32'h0, "R9", "enable reset value", enable, 0);
  endtask

  task automatic testCfg();
    @(negedge clk);
    runEn = 1'b1; cfgWr = 1'b1; cfgData = 32'hFFFF_FFFF;
    @(negedge clk);
    cfgWr = 1'b0;
    #2;
    chk(enable == 32'h0, "R9", "write while running ignored", enable, 0);
    setEn(32'hFFFF_FFFF);
    #2;
    chk(enable == ALL_EN, "R9", "masked enable value", enable, ALL_EN);
  endtask

  task automatic testTcp();
    mkFrame(16'h0800, 5, 6, 33, 0, 0);
    runFrame("R1 R2 TCP odd length", 0, 0, 0);
  endtask

  task automatic testUdpPad();
    mkFrame(16'h0800, 5, 17, 11, 60, 0);
    runFrame("R3 UDP padded", 0, 0, 0);
  endtask

  task automatic testUdpZeroField();
    mkFrame(16'h0800, 5, 17, 20, 0, 1);
    runFrame("R4 UDP zero field", 0, 0, 0);
    chk(fout[40] == 8'h00 && fout[41] == 8'h00, "R4", "UDP field stays zero",
        {fout[40], fout[41]}, 0);
  endtask

  task automatic testUdpFfff();
    logic [15:0] c, w;
    int t;
    mkFrame(16'h0800, 5, 17, 20, 0, 0);
    refModel(ALL_EN);
    c = {fexp[40], fexp[41]};
    w = {fin[42], fin[43]};
    t = int'(w) + int'(c);
    t = (t & 16'hFFFF) + (t >> 16);
    fin[42] = 8'(t >> 8); fin[43] = 8'(t);
    runFrame("R3 zero result", 0, 0, 0);
    chk(fout[40] == 8'hFF && fout[41] == 8'hFF, "R3", "zero sum sent as FFFF",
        {fout[40], fout[41]}, 16'hFFFF);
  endtask

  task automatic testIcmp();
    mkFrame(16'h0800, 6, 1, 24, 0, 0);
    runFrame("R5 R1 ICMP with options", 0, 0, 0);
  endtask

  task automatic testDisabled();
    setEn(32'h0000_0001);
    mkFrame(16'h0800, 5, 6, 40, 0, 0);
    runFrame("R6 TCP disabled", 0, 0, 0);
    chk(fout[50] == fin[50] && fout[51] == fin[51], "R6", "TCP field untouched",
        {fout[50], fout[51]}, {fin[50], fin[51]});
    setEn(32'h0);
    runFrame("R6 all disabled", 0, 0, 0);
    chk(fout[24] == 8'hAB && fout[25] == 8'hCD, "R6", "IP field untouched",
        {fout[24], fout[25]}, 16'hABCD);
    setEn(ALL_EN);
  endtask

  task automatic testOtherTypes();
    mkFrame(16'h8100, 5, 6, 30, 0, 0);
    runFrame("R6 tagged frame", 0, 0, 0);
    mkFrame(16'h0800, 5, 47, 30, 0, 0);
    runFrame("R6 other protocol", 0, 0, 0);
  endtask

  task automatic testStall();
    mkFrame(16'h0800, 5, 6, 27, 0, 0);
    runFrame("R11 TCP under stall", 1, 0, 0);
  endtask

  task automatic testBig();
    mkFrame(16'h0800, 5, 6, 200 - 34, 0, 0);
    runFrame("R8 oversized", 1, 1, 0);
  endtask

  task automatic testPause();
    bit sawReady = 0, sawOut = 0;
    @(negedge clk);
    runEn = 1'b0;
    mkFrame(16'h0800, 5, 6, 30, 0, 0);
    inValid = 1'b1; inData = fin[0]; inLast = 1'b0;
    repeat (10) begin
      @(negedge clk); #2;
      if (inReady) sawReady = 1;
      if (outValid) sawOut = 1;
    end
    chk(!sawReady && !sawOut && !busy, "R10", "paused: nothing started",
        {sawReady, sawOut, busy}, 0);
    inValid = 1'b0;
    runEn = 1'b1;
    runFrame("R10 after resume", 0, 0, 0);
  endtask

  task automatic testDrop();
    bit sawReady = 0;
    mkFrame(16'h0800, 5, 6, 30, 0, 0);
    runFrame("R10 R9 pause in flight", 0, 0, 1);
    @(negedge clk); #2;
    chk(busy == 1'b0, "R10", "busy fell after frame", busy, 0);
    chk(enable == curEn, "R9", "write while busy ignored", enable, curEn);
    @(negedge clk);
    inValid = 1'b1; inData = fin[0];
    repeat (5) begin
      @(negedge clk); #2;
      if (inReady) sawReady = 1;
    end
    chk(!sawReady, "R10", "no new frame while paused", sawReady, 0);
    inValid = 1'b0;
    runEn = 1'b1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testCfg();
    testTcp();
    testUdpPad();
    testUdpZeroField();
    testUdpFfff();
    testIcmp();
    testDisabled();
    testOtherTypes();
    testStall();
    testBig();
    testPause();
    testDrop();
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule